// File: doc/BRIEF.md
# Infrared SIR Pulse Codec

This block sits between a UART's serial bit stream and an infrared transceiver. When infrared mode is on, it changes the transmit side. Each zero bit becomes a short active-low pulse at the start of its bit cell. A one bit leaves the line idle high. The receive side watches the infrared input for low pulses. Each qualified pulse becomes a zero that lasts one full bit cell on the NRZ output. Where no pulse arrives, the output is a one.

All timing comes from the same one-cycle enable that the UART uses, which fires at 16 times the baud rate. The transmit side keeps its own phase counter of these enables, starting at the first enable after reset, and every 16th enable marks the start of a bit cell. The UART is expected to present each bit by that enable.

The receive side takes one decision per pulse, near the middle of a nominal pulse, and drops pulses too short to span two enables. When infrared mode is off, both directions are plain wires between the NRZ side and the pins.

Top module: `irsir_codec`

## Requirements
- R1: During reset and straight after it, with the infrared line idle high, `ir_tx_n` is 1 and `nrz_rx` is 1.
- R2: With `ir_mode`=1, a bit cell starts at enable number 0, 16, 32 and so on, counted from the first `tick16` after reset. If `nrz_tx` is 0 at that enable, `ir_tx_n` goes low on the next clock. It stays low for exactly PULSE_TICKS (3) enable periods, so 12 clocks when `tick16` fires every 4 clocks.
- R3: With `ir_mode`=1, if `nrz_tx` is 1 at a cell-start enable, `ir_tx_n` stays high for that whole cell.
- R4: With `ir_mode`=1, a low on `ir_rx_n` is accepted if, after the SYNC_STAGES-flop synchroniser, it is present on MIN_TICKS (2) enables. `nrz_rx` goes low at the enable that completes the count. It then stays low for exactly OVERSAMPLE (16) enable periods, which is 64 clocks at one enable per 4 clocks.
- R5: With `ir_mode`=1, a low on `ir_rx_n` seen on fewer than MIN_TICKS enables (4 clocks or less at one enable per 4 clocks) leaves `nrz_rx` at 1.
- R6: An accepted pulse that arrives while `nrz_rx` is already low restarts the 16-enable hold. Zero cells in a row therefore give one unbroken low on `nrz_rx`.
- R7: One continuous low on `ir_rx_n` is accepted at most once. A low that lasts longer than a bit cell gives a single 16-enable low on `nrz_rx`.
- R8: With `ir_mode`=0, `ir_tx_n` follows `nrz_tx` and `nrz_rx` follows `ir_rx_n`, with no clock delay and no pulse shaping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick16 | input | 1 | One-cycle enable at 16 times the baud rate |
| ir_mode | input | 1 | 1 selects infrared pulse coding, 0 selects NRZ pass-through |
| nrz_tx | input | 1 | Transmit bit from the UART |
| nrz_rx | output | 1 | Rebuilt receive bit to the UART |
| ir_tx_n | output | 1 | Infrared transmit pin, active low |
| ir_rx_n | input | 1 | Infrared receive pin, active low, asynchronous |

## Verification
The transmit pulse starts one clock after the cell-start enable is sampled. The bench therefore counts the low samples of `ir_tx_n` over each 64-clock cell and also records the offset of the first low sample in that cell.

The receive decision lands at the second enable inside the synchronised pulse. Its exact clock therefore depends on the enable phase, while the 64-clock hold that follows is exact. For this reason each receive case is scored as a total count of low samples and falling edges, taken over a window long enough for every hold to expire.

Pass-through is combinational and is checked one time step after the input changes.

// File: rtl/irsir_pkg.sv
package irsir_pkg;
   // Receive qualifier: armed waits for a valid low, spent waits for the line to return high.
   typedef enum logic {
      DET_ARMED = 1'b0,
      DET_SPENT = 1'b1
   } det_state_t;
endpackage

// File: rtl/irsir_tx_pulser.sv
module irsir_tx_pulser #(
   parameter int OVERSAMPLE  = 16,
   parameter int PULSE_TICKS = 3,
   parameter int PHASE_W     = $clog2(OVERSAMPLE)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               tick,
   input  logic               enable,
   input  logic               bit_in,
   output logic               pulse_n,
   output logic [PHASE_W-1:0] phase
);
   localparam int CNT_W = $clog2(PULSE_TICKS + 1);
   localparam logic [PHASE_W-1:0] LAST_PHASE = PHASE_W'(OVERSAMPLE - 1);

   logic [CNT_W-1:0] left_q;
   logic             cell_start;

   assign cell_start = tick && (phase == '0);

   // Free-running position within the bit cell, shared in step with the UART.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         phase <= '0;
      else if (tick)
         phase <= (phase == LAST_PHASE) ? '0 : phase + 1'b1;
   end

   // Remaining enable periods of the current low pulse.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         left_q <= '0;
      else if (!enable)
         left_q <= '0;
      else if (cell_start && !bit_in)
         left_q <= CNT_W'(PULSE_TICKS);
      else if (tick && (left_q != '0))
         left_q <= left_q - 1'b1;
   end

   assign pulse_n = (left_q == '0);
endmodule

// File: rtl/irsir_rx_sync.sv
module irsir_rx_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);
   generate
      if (STAGES == 0) begin : g_bypass
         assign dout = din;
      end else begin : g_chain
         logic [STAGES-1:0] sr;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               sr <= '1;
            else begin
               sr[0] <= din;
               for (int i = 1; i < STAGES; i++)
                  sr[i] <= sr[i-1];
            end
         end
         assign dout = sr[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/irsir_rx_detect.sv
module irsir_rx_detect
   import irsir_pkg::*;
#(
   parameter int MIN_TICKS = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic enable,
   input  logic line_n,
   output logic hit
);
   localparam int CNT_W = (MIN_TICKS > 1) ? $clog2(MIN_TICKS) : 1;

   det_state_t       state_q;
   logic [CNT_W-1:0] cnt_q;

   assign hit = enable && tick && !line_n && (state_q == DET_ARMED) &&
                (cnt_q == CNT_W'(MIN_TICKS - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= DET_ARMED;
         cnt_q   <= '0;
      end else if (!enable || line_n) begin
         state_q <= DET_ARMED;
         cnt_q   <= '0;
      end else if ((state_q == DET_ARMED) && tick) begin
         if (hit) begin
            state_q <= DET_SPENT;
            cnt_q   <= '0;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end
endmodule

// File: rtl/irsir_rx_stretch.sv
module irsir_rx_stretch #(
   parameter int HOLD_TICKS = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic enable,
   input  logic hit,
   output logic bit_out
);
   localparam int HOLD_W = $clog2(HOLD_TICKS + 1);

   logic [HOLD_W-1:0] hold_q;

   // A new hit reloads even on the enable where the old hold would end.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         hold_q <= '0;
      else if (!enable)
         hold_q <= '0;
      else if (hit)
         hold_q <= HOLD_W'(HOLD_TICKS);
      else if (tick && (hold_q != '0))
         hold_q <= hold_q - 1'b1;
   end

   assign bit_out = (hold_q == '0);
endmodule

// File: rtl/irsir_codec.sv
module irsir_codec #(
   parameter int OVERSAMPLE  = 16,
   parameter int PULSE_TICKS = 3,
   parameter int MIN_TICKS   = 2,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick16,
   input  logic ir_mode,
   input  logic nrz_tx,
   output logic nrz_rx,
   output logic ir_tx_n,
   input  logic ir_rx_n
);
   localparam int PHASE_W    = $clog2(OVERSAMPLE);
   localparam int HOLD_TICKS = OVERSAMPLE;

   generate
      if (OVERSAMPLE < 4 || (OVERSAMPLE & (OVERSAMPLE - 1)) != 0) begin : g_bad_ovs
         $error("OVERSAMPLE must be a power of two, at least 4");
      end
      if (PULSE_TICKS < 1 || PULSE_TICKS >= OVERSAMPLE) begin : g_bad_pulse
         $error("PULSE_TICKS must lie in 1..OVERSAMPLE-1");
      end
      if (MIN_TICKS < 1 || MIN_TICKS > PULSE_TICKS) begin : g_bad_min
         $error("MIN_TICKS must lie in 1..PULSE_TICKS");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("SYNC_STAGES must lie in 0..4");
      end
   endgenerate

   logic               pulse_n;
   logic [PHASE_W-1:0] tx_phase;
   logic               rx_line;
   logic               rx_hit;
   logic               rx_bit;

   irsir_tx_pulser #(
      .OVERSAMPLE (OVERSAMPLE),
      .PULSE_TICKS(PULSE_TICKS),
      .PHASE_W    (PHASE_W)
   ) i_tx (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick   (tick16),
      .enable (ir_mode),
      .bit_in (nrz_tx),
      .pulse_n(pulse_n),
      .phase  (tx_phase)
   );

   irsir_rx_sync #(
      .STAGES(SYNC_STAGES)
   ) i_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (ir_rx_n),
      .dout (rx_line)
   );

   irsir_rx_detect #(
      .MIN_TICKS(MIN_TICKS)
   ) i_det (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (tick16),
      .enable(ir_mode),
      .line_n(rx_line),
      .hit   (rx_hit)
   );

   irsir_rx_stretch #(
      .HOLD_TICKS(HOLD_TICKS)
   ) i_hold (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick   (tick16),
      .enable (ir_mode),
      .hit    (rx_hit),
      .bit_out(rx_bit)
   );

   assign ir_tx_n = ir_mode ? pulse_n : nrz_tx;
   assign nrz_rx  = ir_mode ? rx_bit  : ir_rx_n;
endmodule

// File: rtl/irsir_codec_chk.sv
module irsir_codec_chk #(
   parameter int OVERSAMPLE  = 16,
   parameter int PULSE_TICKS = 3,
   parameter int PHASE_W     = 4
) (
   input logic               clk,
   input logic               rst_n,
   input logic               tick,
   input logic               mode,
   input logic               nrz_tx,
   input logic               ir_tx_n,
   input logic               nrz_rx,
   input logic               rx_line,
   input logic [PHASE_W-1:0] phase
);
   localparam int LW = $clog2(OVERSAMPLE + 2);

   logic [LW-1:0] low_ticks;

   // Enables seen while the transmit pin is held low in infrared mode.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         low_ticks <= '0;
      else if (!mode || ir_tx_n)
         low_ticks <= '0;
      else if (tick && (low_ticks != LW'(OVERSAMPLE)))
         low_ticks <= low_ticks + 1'b1;
   end

   assert_zero_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (mode && tick && (phase == '0) && !nrz_tx) |=> (!ir_tx_n || !mode));

   assert_pulse_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
      low_ticks <= LW'(PULSE_TICKS));

   assert_one_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (mode && tick && (phase == '0) && nrz_tx) |=> (ir_tx_n || !mode));

   assert_rx_fall_on_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (mode && $past(mode) && $fell(nrz_rx)) |-> $past(tick));

   assert_rx_needs_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (mode && $past(mode) && $fell(nrz_rx)) |-> !$past(rx_line));
endmodule

bind irsir_codec irsir_codec_chk #(
   .OVERSAMPLE (OVERSAMPLE),
   .PULSE_TICKS(PULSE_TICKS),
   .PHASE_W    (PHASE_W)
) i_irsir_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .tick   (tick16),
   .mode   (ir_mode),
   .nrz_tx (nrz_tx),
   .ir_tx_n(ir_tx_n),
   .nrz_rx (nrz_rx),
   .rx_line(rx_line),
   .phase  (tx_phase)
);

// File: tb/test_irsir_codec.sv
module test_irsir_codec;
   localparam int TICK_DIV = 4;
   localparam int OVS      = 16;
   localparam int PULSE    = 3;
   localparam int CELL_CLK = OVS * TICK_DIV;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic rst_n = 1'b0, tick16 = 1'b0, ir_mode = 1'b1, nrz_tx = 1'b1, ir_rx_n = 1'b1;
   logic nrz_rx, ir_tx_n;

   irsir_codec i_irsir_codec (
      .clk(clk), .rst_n(rst_n), .tick16(tick16), .ir_mode(ir_mode),
      .nrz_tx(nrz_tx), .nrz_rx(nrz_rx), .ir_tx_n(ir_tx_n), .ir_rx_n(ir_rx_n)
   );

   int n_checks = 0, n_errors = 0;
   bit finished = 1'b0;

   task automatic check(bit ok, string req, string what, int act, int exp);
      n_checks++;
      if (!ok) begin
         n_errors++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // Transmit scoreboard: driver queues bits, the cell process drives and scores them.
   bit tx_q[$];
   int tx_exp_q[$];
   bit idle_tx = 1'b1, ticking = 1'b0, cell_live = 1'b0;
   int div = 0, tick_no = 0, cell_pos = 0, cell_exp = 0, cell_lows = 0, cell_first = -1;

   task automatic queue_tx(bit b);
      tx_q.push_back(b);
      tx_exp_q.push_back(b ? 0 : PULSE * TICK_DIV);
   endtask

   always @(negedge clk) begin
      if (ticking) begin
         if (div == 0 && (tick_no % OVS) == 0) begin
            if (cell_live) begin
               if (cell_exp != 0) begin
                  check(cell_lows == cell_exp, "R2", "low clocks in zero cell", cell_lows, cell_exp);
                  check(cell_first == 1, "R2", "pulse start offset", cell_first, 1);
               end else begin
                  check(cell_lows == 0, "R3", "low clocks in one cell", cell_lows, 0);
               end
            end
            if (tx_q.size() != 0) begin
               nrz_tx   = tx_q.pop_front();
               cell_exp = tx_exp_q.pop_front();
               cell_live = 1'b1;
            end else begin
               nrz_tx    = idle_tx;
               cell_live = 1'b0;
            end
            cell_pos = 0; cell_lows = 0; cell_first = -1;
         end
         if (!ir_tx_n) begin
            cell_lows++;
            if (cell_first < 0) cell_first = cell_pos;
         end
         cell_pos++;
         tick16 = (div == 0);
         if (div == 0) tick_no++;
         div = (div + 1) % TICK_DIV;
      end
   end

   // Receive scoreboard: expected low and fall counts per window.
   int    rx_exp_lows[$], rx_exp_falls[$];
   string rx_exp_req[$];
   bit    rx_win = 1'b0, rx_close = 1'b0, rx_prev = 1'b1;
   int    rx_lows = 0, rx_falls = 0;

   always @(negedge clk) begin
      if (rx_close) begin
         string req;
         int el, ef;
         req = rx_exp_req.pop_front();
         el  = rx_exp_lows.pop_front();
         ef  = rx_exp_falls.pop_front();
         check(rx_lows == el, req, "nrz_rx low clocks", rx_lows, el);
         check(rx_falls == ef, req, "nrz_rx falling edges", rx_falls, ef);
         rx_close = 1'b0;
         rx_win   = 1'b0;
      end else if (rx_win) begin
         if (!nrz_rx) rx_lows++;
         if (rx_prev && !nrz_rx) rx_falls++;
      end
      rx_prev = nrz_rx;
   end

   task automatic pulse(int len);
      @(negedge clk);
      ir_rx_n = 1'b0;
      repeat (len) @(negedge clk);
      ir_rx_n = 1'b1;
   endtask

   task automatic rx_open();
      @(posedge clk);
      rx_lows = 0; rx_falls = 0; rx_win = 1'b1;
   endtask

   task automatic rx_expect(string req, int lows, int falls);
      repeat (3 * CELL_CLK) @(negedge clk);
      rx_exp_req.push_back(req);
      rx_exp_lows.push_back(lows);
      rx_exp_falls.push_back(falls);
      @(posedge clk);
      rx_close = 1'b1;
      repeat (2) @(negedge clk);
   endtask

   initial begin
      queue_tx(1'b0); queue_tx(1'b1); queue_tx(1'b0); queue_tx(1'b0); queue_tx(1'b1);
      repeat (5) @(negedge clk);
      check(ir_tx_n == 1'b1, "R1", "ir_tx_n in reset", int'(ir_tx_n), 1);
      check(nrz_rx == 1'b1, "R1", "nrz_rx in reset", int'(nrz_rx), 1);
      rst_n = 1'b1;
      @(posedge clk);
      ticking = 1'b1;
      @(negedge clk);
      #1;
      check(ir_tx_n == 1'b1, "R1", "ir_tx_n after reset", int'(ir_tx_n), 1);
      check(nrz_rx == 1'b1, "R1", "nrz_rx after reset", int'(nrz_rx), 1);

      // Transmit cells (R2, R3) are scored by the cell process.
      wait (tx_q.size() == 0);
      repeat (CELL_CLK + 4) @(negedge clk);

      // R4: nominal pulse and the two-enable boundary.
      rx_open(); pulse(12); rx_expect("R4", CELL_CLK, 1);
      rx_open(); pulse(8);  rx_expect("R4", CELL_CLK, 1);
      // R5: short lows are dropped.
      rx_open(); pulse(4);  rx_expect("R5", 0, 0);
      rx_open(); pulse(1);  rx_expect("R5", 0, 0);
      // R6: zero zero, then zero one zero.
      rx_open(); pulse(12); repeat (CELL_CLK - 13) @(negedge clk); pulse(12);
      rx_expect("R6", 2 * CELL_CLK, 1);
      rx_open(); pulse(12); repeat (2 * CELL_CLK - 13) @(negedge clk); pulse(12);
      rx_expect("R6", 2 * CELL_CLK, 2);
      // R7: a low longer than a cell is accepted once.
      rx_open(); pulse(160); rx_expect("R7", CELL_CLK, 1);

      // R8: pass-through with infrared mode off.
      @(posedge clk);
      ir_mode = 1'b0; idle_tx = 1'b0;
      repeat (CELL_CLK + 6) @(negedge clk);
      #1;
      check(ir_tx_n == 1'b0, "R8", "ir_tx_n follows nrz_tx=0", int'(ir_tx_n), 0);
      repeat (20) @(negedge clk);
      #1;
      check(ir_tx_n == 1'b0, "R8", "ir_tx_n stays low, no pulse", int'(ir_tx_n), 0);
      @(posedge clk);
      idle_tx = 1'b1;
      repeat (CELL_CLK + 6) @(negedge clk);
      #1;
      check(ir_tx_n == 1'b1, "R8", "ir_tx_n follows nrz_tx=1", int'(ir_tx_n), 1);
      @(negedge clk);
      ir_rx_n = 1'b0;
      #1;
      check(nrz_rx == 1'b0, "R8", "nrz_rx follows ir_rx_n=0", int'(nrz_rx), 0);
      @(negedge clk);
      ir_rx_n = 1'b1;
      #1;
      check(nrz_rx == 1'b1, "R8", "nrz_rx follows ir_rx_n=1", int'(nrz_rx), 1);

      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

   initial begin
      #1500000;
      if (!finished) begin
         n_checks++;
         n_errors++;
         $display("FAIL watchdog (run did not complete): actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   end
endmodule